// File: doc/BRIEF.md
# Multi-Plane Request-Grant Cell Dispatcher

This block sits where a source line card meets a switch fabric built from five parallel planes. Cells arrive with a destination tag and are parked in an eight-entry buffer. For each cell, the block first sends a request to the destination on one plane. It then waits for that destination's grant to come back on the same plane, and only then sends the cell on that plane. Requests for successive cells rotate over the planes that are in service. Four planes carry traffic. The fifth is held back and steps into the rotation when one of the four is flagged as failed.

Each plane can have at most one outstanding exchange, tracked by a per-plane record that holds the destination and the buffer slot. A grant that matches no outstanding request is thrown away and counted. A request that sees no grant within a programmable number of cycles is withdrawn and sent again on a later plane. Cells for one destination always leave in the order they arrived, whatever order their grants come back in.

Top module: `plane_dispatch`

## Requirements
- R1: There are five planes, indexed 0 to 4. The in-service set is the four lowest-indexed planes whose failure flag is low, so with no failures plane 4 is the spare. At most one request leaves per cycle, and no more than four planes have an exchange open.
- R2: Successive requests take the next in-service plane at or after a rotating pointer. After a request on plane p, the pointer moves to p+1, wrapping from 4 to 0. With no failures, back-to-back single cells use planes 0, 1, 2, 3, 0, and so on.
- R3: A grant on plane p is accepted only if plane p has an open, not yet granted request whose destination equals the grant's destination. The cell then leaves on plane p, with its own destination and data.
- R4: A grant that fails the R3 match is dropped and raises the error count by one. The count saturates at its maximum, and no cell is sent because of that grant.
- R5: A request is presented on the cycle after the clock edge that accepts the cell. The cell is presented on the cycle after the edge that accepts its grant.
- R6: When an in-service plane fails, the next non-failed plane takes its place and the rotation pointer is left where it was. Example: after the sequence ending on plane 3, failing plane 1 gives the sequence 4, 0, 2, 3.
- R7: A plane with an open exchange is skipped by the rotation until the exchange ends (the cell is sent or the request is withdrawn).
- R8: With the timeout input T nonzero, a request that has no accepted grant by the T-th edge after its issue is withdrawn and reissued on the next free in-service plane in rotation. A later grant on the old plane counts as an error (R4). T = 0 disables the timeout.
- R9: Cells with the same destination leave in arrival order. A granted cell waits while an older cell for that destination is still held.
- R10: The buffer holds eight cells. in_ready is low exactly while all eight slots are occupied, and rises on the cycle after a slot is freed by sending its cell.
- R11: An open exchange on a plane that fails is withdrawn at once and reissued on a surviving plane, even if its grant has already arrived.
- R12: After reset, in_ready is high, and no request or cell is presented on any plane. The error count is zero and the pointer is at plane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_cycles | input | 8 | Grant timeout in cycles, 0 disables |
| in_valid | input | 1 | Cell offered |
| in_ready | output | 1 | Buffer has a free slot |
| in_dest | input | 4 | Destination of the offered cell |
| in_data | input | 16 | Payload of the offered cell |
| plane_fail | input | 5 | Per-plane failure flag |
| req_valid | output | 5 | Per-plane request strobe |
| req_dest | output | 20 | Per-plane request destination, plane p at bits 4p+3:4p |
| gnt_valid | input | 5 | Per-plane grant strobe |
| gnt_dest | input | 20 | Per-plane grant destination, plane p at bits 4p+3:4p |
| cell_valid | output | 5 | Per-plane cell strobe |
| cell_dest | output | 20 | Per-plane cell destination, plane p at bits 4p+3:4p |
| cell_data | output | 80 | Per-plane cell payload, plane p at bits 16p+15:16p |
| err_cnt | output | 8 | Count of dropped grants, saturating |

## Verification
The assertions take for granted that grants arrive as single-cycle strobes. They also assume that failure flags and the timeout value change only between clock edges, and that at most four planes are ever treated as usable. The stimulus drives every input on the falling edge and holds each grant for exactly one rising edge. It raises failure flags one at a time, and it offers a cell only when in_ready is high, except in the one step that probes the full buffer.

// File: rtl/plane_dispatch.sv
module plane_dispatch #(
  parameter int NPL    = 5,
  parameter int NACT   = 4,
  parameter int DEPTH  = 8,
  parameter int DEST_W = 4,
  parameter int DATA_W = 16,
  parameter int TMO_W  = 8,
  parameter int ERR_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TMO_W-1:0]      tmo_cycles,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DEST_W-1:0]     in_dest,
  input  logic [DATA_W-1:0]     in_data,
  input  logic [NPL-1:0]        plane_fail,
  output logic [NPL-1:0]        req_valid,
  output logic [NPL*DEST_W-1:0] req_dest,
  input  logic [NPL-1:0]        gnt_valid,
  input  logic [NPL*DEST_W-1:0] gnt_dest,
  output logic [NPL-1:0]        cell_valid,
  output logic [NPL*DEST_W-1:0] cell_dest,
  output logic [NPL*DATA_W-1:0] cell_data,
  output logic [ERR_W-1:0]      err_cnt
);

  localparam int PW = $clog2(NPL);
  localparam int IW = $clog2(DEPTH);
  localparam logic [1:0] S_FREE = 2'd0, S_WAIT = 2'd1, S_PEND = 2'd2, S_GRNT = 2'd3;
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [1:0]        st      [DEPTH];
  logic [DEST_W-1:0] e_dest  [DEPTH];
  logic [DATA_W-1:0] e_data  [DEPTH];
  logic [DEPTH-1:0]  e_older [DEPTH];
  logic [PW-1:0]     e_plane [DEPTH];

  logic [NPL-1:0]    trk_valid, trk_gnt;
  logic [DEST_W-1:0] trk_dest [NPL];
  logic [IW-1:0]     trk_idx  [NPL];
  logic [TMO_W-1:0]  trk_tmr  [NPL];
  logic [PW-1:0]     rr_ptr;

  logic [NPL-1:0]    elig, g_ok, g_bad, t_hit, rel;
  logic              free_any, wait_any, send_go, pick_ok, issue, accept;
  logic [IW-1:0]     alloc_idx, wait_idx, send_idx;
  logic [PW-1:0]     pick_pl, send_pl;
  logic [DEPTH-1:0]  same_d;
  logic [ERR_W-1:0]  err_nx;

  always_comb begin
    automatic int n = 0;
    elig = '0;
    for (int p = 0; p < NPL; p++)
      if (!plane_fail[p] && n < NACT) begin
        elig[p] = 1'b1;
        n++;
      end
  end

  always_comb begin
    free_any = 1'b0; alloc_idx = '0;
    wait_any = 1'b0; wait_idx  = '0;
    send_go  = 1'b0; send_idx  = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (st[i] == S_FREE) begin free_any = 1'b1; alloc_idx = IW'(i); end
      if (st[i] == S_WAIT) begin wait_any = 1'b1; wait_idx = IW'(i); end
      if (st[i] == S_GRNT && e_older[i] == '0 && !plane_fail[e_plane[i]]) begin
        send_go = 1'b1; send_idx = IW'(i);
      end
    end
  end

  assign send_pl  = e_plane[send_idx];
  assign in_ready = free_any;
  assign accept   = in_valid && free_any;

  always_comb begin
    pick_ok = 1'b0; pick_pl = '0;
    for (int off = NPL-1; off >= 0; off--) begin
      automatic int q = int'(rr_ptr) + off;
      if (q >= NPL) q = q - NPL;
      if (elig[q] && !trk_valid[q]) begin pick_ok = 1'b1; pick_pl = PW'(q); end
    end
  end

  assign issue = pick_ok && wait_any;

  always_comb begin
    for (int p = 0; p < NPL; p++) begin
      g_ok[p]  = gnt_valid[p] && trk_valid[p] && !trk_gnt[p] && !plane_fail[p] &&
                 trk_dest[p] == gnt_dest[p*DEST_W +: DEST_W];
      g_bad[p] = gnt_valid[p] && !g_ok[p];
      t_hit[p] = trk_valid[p] && !trk_gnt[p] && !g_ok[p] && tmo_cycles != '0 &&
                 (trk_tmr[p] + TMO_W'(1)) >= tmo_cycles;
      rel[p]   = trk_valid[p] && (plane_fail[p] || t_hit[p]);
    end
  end

  always_comb
    for (int j = 0; j < DEPTH; j++)
      same_d[j] = st[j] != S_FREE && e_dest[j] == in_dest && !(send_go && send_idx == IW'(j));

  always_comb begin
    automatic int s = int'(err_cnt) + $countones(g_bad);
    if (s > int'(ERR_MAX)) s = int'(ERR_MAX);
    err_nx = ERR_W'(s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st[i] <= S_FREE; e_dest[i] <= '0; e_data[i] <= '0;
        e_older[i] <= '0; e_plane[i] <= '0;
      end
      for (int p = 0; p < NPL; p++) begin
        trk_dest[p] <= '0; trk_idx[p] <= '0; trk_tmr[p] <= '0;
      end
      trk_valid <= '0; trk_gnt <= '0; rr_ptr <= '0;
      req_valid <= '0; req_dest <= '0;
      cell_valid <= '0; cell_dest <= '0; cell_data <= '0;
      err_cnt <= '0;
    end else begin
      req_valid  <= '0;
      cell_valid <= '0;
      err_cnt    <= err_nx;

      for (int p = 0; p < NPL; p++) begin
        if (rel[p]) begin
          trk_valid[p] <= 1'b0;
          trk_gnt[p]   <= 1'b0;
          st[trk_idx[p]] <= S_WAIT;
        end else if (send_go && send_pl == PW'(p)) begin
          trk_valid[p] <= 1'b0;
          trk_gnt[p]   <= 1'b0;
        end else if (g_ok[p]) begin
          trk_gnt[p] <= 1'b1;
          st[trk_idx[p]] <= S_GRNT;
        end else if (trk_valid[p] && !trk_gnt[p] && tmo_cycles != '0) begin
          trk_tmr[p] <= trk_tmr[p] + TMO_W'(1);
        end
        if (issue && pick_pl == PW'(p)) begin
          trk_valid[p] <= 1'b1;
          trk_gnt[p]   <= 1'b0;
          trk_dest[p]  <= e_dest[wait_idx];
          trk_idx[p]   <= wait_idx;
          trk_tmr[p]   <= '0;
          req_valid[p] <= 1'b1;
          req_dest[p*DEST_W +: DEST_W] <= e_dest[wait_idx];
        end
      end

      if (issue) begin
        st[wait_idx]      <= S_PEND;
        e_plane[wait_idx] <= pick_pl;
        rr_ptr <= (pick_pl == PW'(NPL-1)) ? '0 : pick_pl + PW'(1);
      end

      if (send_go) begin
        st[send_idx] <= S_FREE;
        cell_valid[send_pl] <= 1'b1;
        cell_dest[send_pl*DEST_W +: DEST_W] <= e_dest[send_idx];
        cell_data[send_pl*DATA_W +: DATA_W] <= e_data[send_idx];
        for (int i = 0; i < DEPTH; i++) e_older[i][send_idx] <= 1'b0;
      end

      if (accept) begin
        st[alloc_idx]      <= S_WAIT;
        e_dest[alloc_idx]  <= in_dest;
        e_data[alloc_idx]  <= in_data;
        e_older[alloc_idx] <= same_d;
      end
    end
  end

endmodule

// File: rtl/plane_dispatch_chk.sv
module plane_dispatch_chk #(
  parameter int NPL   = 5,
  parameter int NACT  = 4,
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPL-1:0]   req_valid,
  input logic [NPL-1:0]   cell_valid,
  input logic [NPL-1:0]   gnt_valid,
  input logic [ERR_W-1:0] err_cnt,
  input logic [NPL-1:0]   trk_valid,
  input logic [NPL-1:0]   trk_gnt,
  input logic [NPL-1:0]   elig
);

  assert_one_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_valid));

  assert_busy_limit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(trk_valid) <= NACT);

  assert_req_in_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid & ~$past(elig)) == '0);

  assert_cell_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid & ~$past(trk_gnt)) == '0);

  assert_grant_needs_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_gnt & ~$past(trk_gnt) & ~$past(trk_valid)) == '0);

  assert_err_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != $past(err_cnt)) |-> ($past(gnt_valid) != '0));

endmodule

bind plane_dispatch plane_dispatch_chk #(.NPL(NPL), .NACT(NACT), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cell_valid(cell_valid),
  .gnt_valid(gnt_valid), .err_cnt(err_cnt), .trk_valid(trk_valid),
  .trk_gnt(trk_gnt), .elig(elig)
);

// File: tb/plane_dispatch_tb.sv
module plane_dispatch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [3:0] VEC_DEST [NV] = '{4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8};
  localparam int         VEC_PL   [NV] = '{0, 1, 2, 3, 0, 1, 2, 3};

  logic clk = 0, rst_n = 0;
  logic [7:0]  tmo_cycles = 0;
  logic        in_valid = 0, in_ready;
  logic [3:0]  in_dest = 0;
  logic [15:0] in_data = 0;
  logic [4:0]  plane_fail = 0, req_valid, gnt_valid = 0, cell_valid;
  logic [19:0] req_dest, gnt_dest = 0, cell_dest;
  logic [79:0] cell_data;
  logic [7:0]  err_cnt;

  int tests = 0, fails = 0;
  int rq_pl[$], rq_d[$], cq_pl[$], cq_d[$], cq_x[$];

  plane_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .tmo_cycles(tmo_cycles), .in_valid(in_valid),
    .in_ready(in_ready), .in_dest(in_dest), .in_data(in_data),
    .plane_fail(plane_fail), .req_valid(req_valid), .req_dest(req_dest),
    .gnt_valid(gnt_valid), .gnt_dest(gnt_dest), .cell_valid(cell_valid),
    .cell_dest(cell_dest), .cell_data(cell_data), .err_cnt(err_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    #1;
    for (int p = 0; p < 5; p++) begin
      if (req_valid[p]) begin rq_pl.push_back(p); rq_d.push_back(int'(req_dest[p*4 +: 4])); end
      if (cell_valid[p]) begin
        cq_pl.push_back(p); cq_d.push_back(int'(cell_dest[p*4 +: 4]));
        cq_x.push_back(int'(cell_data[p*16 +: 16]));
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0; gnt_valid = 0; plane_fail = 0; tmo_cycles = 0;
    repeat (3) @(negedge clk);
    rq_pl.delete(); rq_d.delete(); cq_pl.delete(); cq_d.delete(); cq_x.delete();
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic push(input logic [3:0] d, input logic [15:0] x);
    in_valid = 1; in_dest = d; in_data = x;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic grant(input int p, input logic [3:0] d);
    gnt_valid[p] = 1; gnt_dest[p*4 +: 4] = d;
    @(negedge clk);
    gnt_valid = 0;
  endtask

  task automatic get_req(output int pl, output int d, output int n);
    n = 0;
    while (rq_pl.size() == 0 && n < 100) begin @(negedge clk); n++; end
    if (rq_pl.size() != 0) begin pl = rq_pl.pop_front(); d = rq_d.pop_front(); end
    else begin pl = -1; d = -1; end
  endtask

  task automatic get_cell(output int pl, output int d, output int x, output int n);
    n = 0;
    while (cq_pl.size() == 0 && n < 100) begin @(negedge clk); n++; end
    if (cq_pl.size() != 0) begin pl = cq_pl.pop_front(); d = cq_d.pop_front(); x = cq_x.pop_front(); end
    else begin pl = -1; d = -1; x = -1; end
  endtask

  task automatic one_cell(input logic [3:0] d, input logic [15:0] x, input int exp_pl, input string req);
    int pl, rd, n, cp, cd, cx;
    push(d, x);
    get_req(pl, rd, n);
    check(pl == exp_pl, req, pl, exp_pl);
    check(n == 1, "R5 request latency", n, 1);
    check(rd == int'(d), "R3 request dest", rd, int'(d));
    grant(pl, d);
    get_cell(cp, cd, cx, n);
    check(n == 1, "R5 cell latency", n, 1);
    check(cp == pl, "R3 cell plane", cp, pl);
    check(cx == int'(x) && cd == int'(d), "R3 cell payload", cx, int'(x));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int pl, rd, n, cp, cd, cx;
    do_reset();
    check(in_ready == 1, "R12 in_ready", int'(in_ready), 1);
    check(req_valid == 0 && cell_valid == 0, "R12 outputs idle", int'(req_valid | cell_valid), 0);
    check(err_cnt == 0, "R12 err_cnt", int'(err_cnt), 0);

    for (int i = 0; i < NV; i++)
      one_cell(VEC_DEST[i], 16'hA000 + 16'(i), VEC_PL[i], "R2 rotation");

    // R6: pointer left at 4, plane 1 fails, spare joins
    plane_fail[1] = 1;
    one_cell(4'd9,  16'hB000, 4, "R6 spare order");
    one_cell(4'd10, 16'hB001, 0, "R6 spare order");
    one_cell(4'd11, 16'hB002, 2, "R6 spare order");
    one_cell(4'd12, 16'hB003, 3, "R6 spare order");

    // R4: mismatched grants
    do_reset();
    push(4'd3, 16'h0333);
    get_req(pl, rd, n);
    grant(2, 4'd3);
    grant(0, 4'd7);
    @(negedge clk);
    check(err_cnt == 2, "R4 err count", int'(err_cnt), 2);
    check(cq_pl.size() == 0, "R4 no cell on bad grant", cq_pl.size(), 0);
    grant(0, 4'd3);
    get_cell(cp, cd, cx, n);
    check(cp == 0 && cx == 16'h0333, "R3 cell after good grant", cp, 0);

    // R7: busy plane skipped
    do_reset();
    for (int i = 0; i < 4; i++) push(4'(i), 16'(16'h0100 + i));
    repeat (4) begin get_req(pl, rd, n); end
    grant(1, 4'd1); grant(2, 4'd2); grant(3, 4'd3);
    repeat (3) get_cell(cp, cd, cx, n);
    push(4'd9, 16'h0909);
    get_req(pl, rd, n);
    check(pl == 1, "R7 skip busy plane 0", pl, 1);

    // R8: timeout and reissue
    do_reset();
    tmo_cycles = 4;
    push(4'd6, 16'h0666);
    get_req(pl, rd, n);
    check(pl == 0, "R8 first plane", pl, 0);
    get_req(pl, rd, n);
    check(pl == 1 && rd == 6, "R8 reissue plane", pl, 1);
    grant(0, 4'd6);
    @(negedge clk);
    check(err_cnt == 1, "R8 stale grant counted", int'(err_cnt), 1);
    grant(1, 4'd6);
    get_cell(cp, cd, cx, n);
    check(cp == 1 && cx == 16'h0666, "R8 cell on reissue plane", cp, 1);

    // R9: same destination order
    do_reset();
    push(4'd5, 16'h0001);
    push(4'd5, 16'h0002);
    get_req(pl, rd, n); get_req(pl, rd, n);
    grant(1, 4'd5);
    repeat (3) @(negedge clk);
    check(cq_pl.size() == 0, "R9 younger held", cq_pl.size(), 0);
    grant(0, 4'd5);
    get_cell(cp, cd, cx, n);
    check(cp == 0 && cx == 1, "R9 older first", cx, 1);
    get_cell(cp, cd, cx, n);
    check(cp == 1 && cx == 2 && n == 1, "R9 younger next", cx, 2);

    // R11: failure with open request
    do_reset();
    push(4'd2, 16'h0222);
    get_req(pl, rd, n);
    plane_fail[0] = 1;
    get_req(pl, rd, n);
    check(pl == 1 && rd == 2, "R11 reissue after fail", pl, 1);
    grant(1, 4'd2);
    get_cell(cp, cd, cx, n);
    check(cp == 1 && cx == 16'h0222, "R11 cell on survivor", cp, 1);

    // R10: backpressure
    do_reset();
    for (int i = 0; i < 8; i++) push(4'(i), 16'(16'h0800 + i));
    check(in_ready == 0, "R10 full", int'(in_ready), 0);
    in_valid = 1; in_dest = 4'd15; in_data = 16'hFFFF;
    @(negedge clk);
    in_valid = 0;
    check(in_ready == 0, "R10 still full", int'(in_ready), 0);
    grant(0, 4'd0);
    get_cell(cp, cd, cx, n);
    check(cp == 0 && cx == 16'h0800, "R10 drained cell", cx, 16'h0800);
    check(in_ready == 1, "R10 slot freed", int'(in_ready), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule